// File: doc/BRIEF.md
# Adaptive Interrupt Acceptance Delay Counter

This block sits next to the interrupt logic of a pipelined processor and decides in which cycles a pending interrupt may be taken. An interrupt can be deferred because an instruction that is still in flight has switched interrupts off. When that happens, the block holds off acceptance for a number of cycles in which the front end advances. During that time the pipeline keeps working through the ordinary instruction stream. It does not repeatedly flush that stream and refetch handler code.

The length of the hold-off adapts to the program. Each time a deferred interrupt turns up at commit, the base hold-off grows by a fixed step and the down-counter restarts from the new base. An executed interrupt-enable instruction returns the base to its minimum. If growing the base would push it past a limit, the interrupt is treated as stuck. The block then raises a one-cycle exception request and starts over from the minimum. Flushing the pipeline and fetching the handler are left to the surrounding logic.

Top module: `aid_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the base hold-off to the minimum (10), the down-counter to zero and the exception request low, so that after reset a pending, enabled interrupt is accepted at once.
- R2: `accept_ok` is high in exactly those cycles where the down-counter is zero, `irq_enabled` is high and `irq_pending` is high.
- R3: A `defer_hit` pulse, without a commit event in the same cycle, loads the down-counter with the base hold-off, using the base as it stands after this cycle's update.
- R4: The down-counter decreases by one only in cycles with `fe_advance` high. It holds its value in all other cycles and stops at zero.
- R5: A `commit_hit` pulse without `ei_exec` raises the base by the step (10) and reloads the down-counter with the new base, provided the new base does not exceed the limit (1000).
- R6: `ei_exec` returns the base to the minimum and takes priority over a `commit_hit` in the same cycle. It leaves the down-counter to its other rules.
- R7: If a `commit_hit` without `ei_exec` would raise the base above the limit, then in the next cycle `stuck_exc` is high, the base is back at the minimum and the down-counter is zero.
- R8: `stuck_exc` is never high in two consecutive cycles.
- R9: The base stays between the minimum and the limit, and the down-counter never exceeds the limit.
- R10: When `defer_hit` and `commit_hit` (without `ei_exec`) arrive in the same cycle, the commit rule decides the down-counter's next value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pending | input | 1 | An interrupt request is pending |
| irq_enabled | input | 1 | Interrupts are currently enabled |
| fe_advance | input | 1 | The front end advanced this cycle |
| defer_hit | input | 1 | An interrupt was deferred because an in-flight instruction disabled interrupts |
| commit_hit | input | 1 | A deferred interrupt was observed at the commit stage |
| ei_exec | input | 1 | An interrupt-enable instruction executed |
| accept_ok | output | 1 | A pending interrupt may be accepted this cycle |
| stuck_exc | output | 1 | One-cycle stuck-interrupt exception request |

## Verification
The bench aims first at the counter's clock gating. It holds `fe_advance` low for long stretches after a deferral. A counter that ran on every clock would then grant acceptance far too early. It drives deferral and commit in the same cycle, and enable and commit in the same cycle. A wrong priority shows up there as a reload with the old base, or as a base that keeps growing after an enable. It walks the base up to exactly the limit and then one step beyond. An off-by-one in the limit test shows up as an exception one commit too early or too late, or as a pulse that lasts two cycles. A long random mix of events then compares every cycle against a behavioural model.

// File: rtl/aid_pkg.sv
package aid_pkg;

  // Base after one more deferral reached commit.
  function automatic logic [31:0] grow_base(input logic [31:0] base, input logic [31:0] step);
    return base + step;
  endfunction

  // True when a candidate base lies beyond the stuck limit.
  function automatic logic over_limit(input logic [31:0] cand, input logic [31:0] limit);
    return cand > limit;
  endfunction

  // One front-end step of the hold-off counter, floored at zero.
  function automatic logic [31:0] step_down(input logic [31:0] cnt);
    return (cnt == 32'd0) ? 32'd0 : cnt - 32'd1;
  endfunction

  // Acceptance rule.
  function automatic logic holdoff_clear(input logic [31:0] cnt, input logic en, input logic pend);
    return (cnt == 32'd0) && en && pend;
  endfunction

endpackage

// File: rtl/aid_base_track.sv
module aid_base_track #(
  parameter int unsigned MIN_HOLD = 10,
  parameter int unsigned STEP     = 10,
  parameter int unsigned LIMIT    = 1000,
  parameter int unsigned CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_hit,
  input  logic             ei_exec,
  output logic [CNT_W-1:0] base,
  output logic [CNT_W-1:0] base_nxt,
  output logic             escalate,
  output logic             stuck_exc
);
  import aid_pkg::*;

  localparam logic [CNT_W-1:0] BASE_MIN = CNT_W'(MIN_HOLD);

  logic [CNT_W-1:0] grown;
  logic             commit_eff;

  always_comb begin
    grown      = CNT_W'(grow_base(32'(base), 32'(STEP)));
    commit_eff = commit_hit && !ei_exec;
    escalate   = commit_eff && over_limit(32'(grown), 32'(LIMIT));
    if (ei_exec)         base_nxt = BASE_MIN;
    else if (escalate)   base_nxt = BASE_MIN;
    else if (commit_eff) base_nxt = grown;
    else                 base_nxt = base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base      <= BASE_MIN;
      stuck_exc <= 1'b0;
    end else begin
      base      <= base_nxt;
      stuck_exc <= escalate;
    end
  end

endmodule

// File: rtl/aid_holdoff_count.sv
module aid_holdoff_count #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fe_advance,
  input  logic             defer_hit,
  input  logic             commit_hit,
  input  logic             ei_exec,
  input  logic             escalate,
  input  logic [CNT_W-1:0] base_nxt,
  output logic [CNT_W-1:0] cnt
);
  import aid_pkg::*;

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (commit_hit && !ei_exec) cnt_nxt = escalate ? '0 : base_nxt;
    else if (defer_hit)         cnt_nxt = base_nxt;
    else if (fe_advance)        cnt_nxt = CNT_W'(step_down(32'(cnt)));
    else                        cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

endmodule

// File: rtl/aid_accept_gate.sv
module aid_accept_gate #(
  parameter int unsigned CNT_W = 10
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             irq_enabled,
  input  logic             irq_pending,
  output logic             accept_ok
);
  import aid_pkg::*;

  always_comb accept_ok = holdoff_clear(32'(cnt), irq_enabled, irq_pending);

endmodule

// File: rtl/aid_ctrl.sv
module aid_ctrl #(
  parameter int unsigned MIN_HOLD = 10,
  parameter int unsigned STEP     = 10,
  parameter int unsigned LIMIT    = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_pending,
  input  logic irq_enabled,
  input  logic fe_advance,
  input  logic defer_hit,
  input  logic commit_hit,
  input  logic ei_exec,
  output logic accept_ok,
  output logic stuck_exc
);
  localparam int unsigned CNT_W = $clog2(LIMIT + STEP + 1);

  logic [CNT_W-1:0] hold_base;
  logic [CNT_W-1:0] hold_base_nxt;
  logic [CNT_W-1:0] hold_cnt;
  logic             esc_fire;

  aid_base_track #(
    .MIN_HOLD(MIN_HOLD), .STEP(STEP), .LIMIT(LIMIT), .CNT_W(CNT_W)
  ) u_base (
    .clk(clk), .rst(rst), .commit_hit(commit_hit), .ei_exec(ei_exec),
    .base(hold_base), .base_nxt(hold_base_nxt), .escalate(esc_fire),
    .stuck_exc(stuck_exc)
  );

  aid_holdoff_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .fe_advance(fe_advance), .defer_hit(defer_hit),
    .commit_hit(commit_hit), .ei_exec(ei_exec), .escalate(esc_fire),
    .base_nxt(hold_base_nxt), .cnt(hold_cnt)
  );

  aid_accept_gate #(.CNT_W(CNT_W)) u_gate (
    .cnt(hold_cnt), .irq_enabled(irq_enabled), .irq_pending(irq_pending),
    .accept_ok(accept_ok)
  );

endmodule

// File: rtl/aid_ctrl_chk.sv
module aid_ctrl_chk #(
  parameter int unsigned MIN_HOLD = 10,
  parameter int unsigned STEP     = 10,
  parameter int unsigned LIMIT    = 1000,
  parameter int unsigned CNT_W    = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             fe_advance,
  input logic             defer_hit,
  input logic             commit_hit,
  input logic             ei_exec,
  input logic             accept_ok,
  input logic             stuck_exc,
  input logic [CNT_W-1:0] base,
  input logic [CNT_W-1:0] cnt
);
  logic over;
  always_comb over = (int'(base) + int'(STEP)) > int'(LIMIT);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (int'(base) == int'(MIN_HOLD)) && (cnt == '0) && !stuck_exc);

  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> !accept_ok);

  p_defer_load_r3: assert property (@(posedge clk) disable iff (rst)
    (defer_hit && !commit_hit && !ei_exec) |=> cnt == $past(base));

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!fe_advance && !defer_hit && !commit_hit) |=> $stable(cnt));

  p_dec_adv_r4: assert property (@(posedge clk) disable iff (rst)
    (fe_advance && !defer_hit && !commit_hit && cnt != '0) |=> int'(cnt) == int'($past(cnt)) - 1);

  p_grow_r5: assert property (@(posedge clk) disable iff (rst)
    (commit_hit && !ei_exec && !over) |=> (int'(base) == int'($past(base)) + int'(STEP)) && (cnt == base));

  p_enable_min_r6: assert property (@(posedge clk) disable iff (rst)
    ei_exec |=> int'(base) == int'(MIN_HOLD));

  p_escalate_r7: assert property (@(posedge clk) disable iff (rst)
    (commit_hit && !ei_exec && over) |=> stuck_exc && (int'(base) == int'(MIN_HOLD)) && (cnt == '0));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    stuck_exc |=> !stuck_exc);

  p_bounds_r9: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt) <= int'(LIMIT)) && (int'(base) >= int'(MIN_HOLD)) && (int'(base) <= int'(LIMIT)));

  p_commit_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (defer_hit && commit_hit && !ei_exec && !over) |=> int'(cnt) == int'($past(base)) + int'(STEP));

endmodule

bind aid_ctrl aid_ctrl_chk #(
  .MIN_HOLD(MIN_HOLD), .STEP(STEP), .LIMIT(LIMIT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .fe_advance(fe_advance), .defer_hit(defer_hit),
  .commit_hit(commit_hit), .ei_exec(ei_exec), .accept_ok(accept_ok),
  .stuck_exc(stuck_exc), .base(hold_base), .cnt(hold_cnt)
);

// File: tb/tb_aid_ctrl.sv
`timescale 1ns/1ps
module tb_aid_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_pending = 1'b0, irq_enabled = 1'b0, fe_advance = 1'b0;
  logic defer_hit = 1'b0, commit_hit = 1'b0, ei_exec = 1'b0;
  logic accept_ok, stuck_exc;

  int vectors = 0;
  int miscompares = 0;

  // behavioural model state
  int m_base = 10;
  int m_cnt  = 0;
  int m_exc  = 0;

  always #2.5 clk = ~clk;

  aid_ctrl dut (
    .clk(clk), .rst(rst), .irq_pending(irq_pending), .irq_enabled(irq_enabled),
    .fe_advance(fe_advance), .defer_hit(defer_hit), .commit_hit(commit_hit),
    .ei_exec(ei_exec), .accept_ok(accept_ok), .stuck_exc(stuck_exc)
  );

  task automatic model_clock();
    int nb;
    if (rst) begin
      m_base = 10; m_cnt = 0; m_exc = 0;
    end else begin
      nb = m_base + 10;
      m_exc = 0;
      if (ei_exec) m_base = 10;
      else if (commit_hit) begin
        if (nb > 1000) begin m_exc = 1; m_base = 10; end
        else m_base = nb;
      end
      if (commit_hit && !ei_exec) m_cnt = m_exc ? 0 : nb;
      else if (defer_hit) m_cnt = m_base;
      else if (fe_advance && m_cnt > 0) m_cnt = m_cnt - 1;
    end
  endtask

  task automatic cyc(input bit p, input bit e, input bit a, input bit d,
                     input bit c, input bit i, input string tag);
    bit exp_acc;
    irq_pending = p; irq_enabled = e; fe_advance = a;
    defer_hit = d; commit_hit = c; ei_exec = i;
    #1;
    if (!rst) begin
      exp_acc = (m_cnt == 0) && e && p;
      vectors++;
      if (accept_ok !== exp_acc) begin
        miscompares++;
        $display("FAIL %s accept_ok actual=%b expected=%b", tag, accept_ok, exp_acc);
      end
      vectors++;
      if (stuck_exc !== m_exc[0]) begin
        miscompares++;
        $display("FAIL %s stuck_exc actual=%b expected=%b", tag, stuck_exc, m_exc[0]);
      end
    end
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    repeat (3) cyc(0,0,0,0,0,0,"R1");
    rst = 1'b0;
    // R1: immediate acceptance after reset
    cyc(1,1,0,0,0,0,"R1");
    // R2: gating by enable and pending
    cyc(1,0,1,0,0,0,"R2");
    cyc(0,1,1,0,0,0,"R2");
    // R3: defer loads base 10; R4: no advance keeps it blocked
    cyc(1,1,0,1,0,0,"R3");
    for (int k = 0; k < 25; k++) cyc(1,1,0,0,0,0,"R4");
    for (int k = 0; k < 12; k++) cyc(1,1,1,0,0,0,"R4");
    // R5: growth to 20 and reload
    cyc(1,1,1,0,1,0,"R5");
    for (int k = 0; k < 22; k++) cyc(1,1,(k % 2) == 0,0,0,0,"R5");
    for (int k = 0; k < 12; k++) cyc(1,1,1,0,0,0,"R5");
    // R10: defer and commit together, commit decides (base 30)
    cyc(1,1,1,1,1,0,"R10");
    for (int k = 0; k < 32; k++) cyc(1,1,1,0,0,0,"R10");
    // R6: enable beats commit, then defer loads minimum
    cyc(1,1,1,0,1,1,"R6");
    cyc(1,1,1,1,0,0,"R6");
    for (int k = 0; k < 12; k++) cyc(1,1,1,0,0,0,"R6");
    cyc(1,1,0,1,0,1,"R6");
    for (int k = 0; k < 12; k++) cyc(1,1,1,0,0,0,"R6");
    // R7: climb to the limit, then one step more
    for (int k = 0; k < 99; k++) cyc(1,1,1,0,1,0,"R5");
    cyc(1,1,1,0,1,0,"R7");
    cyc(1,1,1,0,0,0,"R7");
    cyc(1,1,1,0,1,0,"R8");
    cyc(1,1,1,0,0,0,"R8");
    // R9: long random mix
    for (int k = 0; k < 4000; k++) begin
      cyc($urandom_range(0,3) != 0, $urandom_range(0,3) != 0,
          $urandom_range(0,1) == 1, $urandom_range(0,19) == 0,
          $urandom_range(0,9) == 0, $urandom_range(0,99) == 0, "R9");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule